// File: doc/BRIEF.md
# Zero-Substitution Line Decoder with Violation Flag

This block sits on the receive side of a high-rate line port, after clock and data recovery. Each recovered bit arrives as a pair of rails, one for positive marks and one for negative marks, together with a one-cycle bit enable. In NRZ mode the block undoes the zero-substitution code, either B3ZS or HDB3 as picked by a rate-select input. It then delivers single-rail data on the positive output and a one-bit line-code-violation pulse on the negative output. In dual-rail mode the decoder is bypassed and both rails come out unchanged.

A mark with the same polarity as the previous mark is a violation mark (V). A V that completes a legal substitution is removed from the data, and so is the balancing mark (B) that some substitutions insert. Three classes of error are flagged, each for one bit: plain bipolar violations, violations with the wrong parity of B pulses, and excessive zeros. Every result leaves the block a fixed four bit enables after its input bit, and each flag is aligned with the bit it belongs to.

Top module: `zsub_decoder`

## Requirements
- R1: A bit sampled at bit enable k appears on the outputs in the clock cycle after bit enable k+4. The outputs change only in the cycle that follows a bit enable.
- R2: With nrz_mode low, out_pos equals rx_pos and out_neg equals rx_neg for every bit, including bits with both rails high, with no decoding and no flag.
- R3: With nrz_mode high, a legal substitution decodes to all zeros with the flag low. The zero limit N is 3 when b3zs_sel is high (B3ZS) and 4 when low (HDB3). A V is legal when it follows exactly N-1 or N-2 zeros and an odd number of B pulses has arrived since the last V. In the N-2 case, the B mark that precedes those zeros is also output as zero. Marks that alternate in polarity are output as ones.
- R4: A V that follows fewer than N-2 zeros (B3ZS: none; HDB3: none or one) is a bipolar violation. It is output as one with the flag high for that bit only.
- R5: A V that follows N-2 or more zeros but is not legal, for example because an even number of B pulses has arrived since the last V, is a code violation. It is output as one with the flag high.
- R6: The N-th consecutive zero carries a flag; later zeros of the same run do not. All zeros are output as zero.
- R7: In NRZ mode, a bit with both rails high is output as zero with the flag high, and it ends a zero run.
- R8: Reset drives both outputs low. After reset, the first mark is taken as a B pulse. Until the first V has arrived, a V after N-1 or N-2 zeros is legal whatever the B parity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe marking a valid received bit |
| nrz_mode | input | 1 | High: decode to NRZ with violation flag; low: dual-rail pass-through |
| b3zs_sel | input | 1 | High: B3ZS rules (N=3); low: HDB3 rules (N=4) |
| rx_pos | input | 1 | Received positive-mark rail |
| rx_neg | input | 1 | Received negative-mark rail |
| out_pos | output | 1 | NRZ data, or positive rail in dual-rail mode |
| out_neg | output | 1 | Violation flag, or negative rail in dual-rail mode |

## Verification
Every decoded bit and its flag are due on the outputs in the cycle after the fourth bit enable that follows the bit's own enable, because a B mark can only be cleared once its V has arrived. The bench keeps a four-deep queue of expected results and compares, at a falling edge, the entry pushed four enables earlier. A directed test confirms that a bit is still absent after three further enables, present after the fourth, and held unchanged through idle cycles with no enable. Reset values are sampled while reset is held.

// File: rtl/zsub_decoder.sv
`timescale 1ns/1ps
module zsub_decoder #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic nrz_mode,
  input  logic b3zs_sel,
  input  logic rx_pos,
  input  logic rx_neg,
  output logic out_pos,
  output logic out_neg
);
  localparam int IW = $clog2(LAT);
  localparam int ZW = 3;

  logic [LAT-1:0] wd, wf, wp, wn, nd;
  logic [ZW-1:0]  zrun, zlim;
  logic           last_pol, have_mark, seen_v, par;
  logic [IW-1:0]  kidx;

  wire is_p  = rx_pos & ~rx_neg;
  wire is_n  = rx_neg & ~rx_pos;
  wire both  = rx_pos & rx_neg;
  wire mark  = is_p | is_n;
  wire space = ~rx_pos & ~rx_neg;

  assign zlim = b3zs_sel ? ZW'(3) : ZW'(4);
  assign kidx = b3zs_sel ? IW'(2) : IW'(3);

  wire same   = mark & have_mark & (is_p == last_pol);
  wire in_sub = (zrun == zlim - ZW'(1)) | (zrun == zlim - ZW'(2));
  wire legal  = same & in_sub & (par | ~seen_v);
  wire bpv    = same & (zrun < zlim - ZW'(2));
  wire cv     = same & ~legal & ~bpv;
  wire exz    = space & (zrun == zlim - ZW'(1));
  wire kill_b = legal & (zrun == zlim - ZW'(2));
  wire new_d  = mark & ~legal;
  wire new_f  = bpv | cv | exz | both;

  always_comb begin
    nd = {wd[LAT-2:0], new_d};
    if (kill_b) nd[kidx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wd <= '0; wf <= '0; wp <= '0; wn <= '0;
      zrun <= '0; last_pol <= 1'b0; have_mark <= 1'b0;
      seen_v <= 1'b0; par <= 1'b0;
      out_pos <= 1'b0; out_neg <= 1'b0;
    end else if (bit_en) begin
      wd <= nd;
      wf <= {wf[LAT-2:0], new_f};
      wp <= {wp[LAT-2:0], rx_pos};
      wn <= {wn[LAT-2:0], rx_neg};
      out_pos <= nrz_mode ? wd[LAT-1] : wp[LAT-1];
      out_neg <= nrz_mode ? wf[LAT-1] : wn[LAT-1];
      if (!space) zrun <= '0;
      else if (zrun < zlim) zrun <= zrun + ZW'(1);
      if (mark) begin
        have_mark <= 1'b1;
        last_pol  <= is_p;
        if (same) begin
          par    <= 1'b0;
          seen_v <= 1'b1;
        end else begin
          par <= ~par;
        end
      end
    end
  end

  // R1: outputs move only after a bit enable
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(out_pos) && $stable(out_neg)));

  // R3: a legal violation mark enters the window as a clean zero
  assert_legal_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && legal) |=> (!wd[0] && !wf[0]));

  // R4: adjacent same-polarity marks are flagged and kept as data
  assert_bpv_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && same && zrun == '0) |=> (wd[0] && wf[0]));

  // R6: a space never becomes a one, and the N-th space is flagged
  assert_space_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && space) |=> !wd[0]);
  assert_exz_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && space && zrun == zlim - ZW'(1)) |=> wf[0]);

  // R7: both rails high gives zero data with a flag
  assert_both_rails_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && rx_pos && rx_neg) |=> (wf[0] && !wd[0]));
endmodule

// File: tb/zsub_decoder_tb.sv
`timescale 1ns/1ps
module zsub_decoder_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, bit_en, nrz_mode, b3zs_sel, rx_pos, rx_neg;
  logic out_pos, out_neg;
  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  zsub_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .nrz_mode(nrz_mode),
    .b3zs_sel(b3zs_sel), .rx_pos(rx_pos), .rx_neg(rx_neg),
    .out_pos(out_pos), .out_neg(out_neg)
  );

  // row: seg, nrz, b3zs, sym{pos,neg}, expected{out_pos,out_neg}, req
  localparam int NV = 64;
  localparam logic [10:0] VEC [NV] = '{
    // HDB3: legal 000V, B00V (R3, R8), then R4, R5, R6, R7 errors
    11'b1_1_0_10_10_0011, 11'b0_1_0_00_00_0011, 11'b0_1_0_00_00_0011,
    11'b0_1_0_00_00_0011, 11'b0_1_0_10_00_1000, 11'b0_1_0_01_10_0011,
    11'b0_1_0_10_10_0011, 11'b0_1_0_01_00_0011, 11'b0_1_0_00_00_0011,
    11'b0_1_0_00_00_0011, 11'b0_1_0_01_00_0011, 11'b0_1_0_10_10_0011,
    11'b0_1_0_00_00_0011, 11'b0_1_0_00_00_0011, 11'b0_1_0_00_00_0011,
    11'b0_1_0_10_00_0011, 11'b0_1_0_01_10_0100, 11'b0_1_0_01_11_0100,
    11'b0_1_0_10_10_0100, 11'b0_1_0_00_00_0100, 11'b0_1_0_10_11_0100,
    11'b0_1_0_01_10_0101, 11'b0_1_0_10_10_0101, 11'b0_1_0_00_00_0101,
    11'b0_1_0_00_00_0101, 11'b0_1_0_00_00_0101, 11'b0_1_0_10_11_0101,
    11'b0_1_0_01_10_0110, 11'b0_1_0_00_00_0110, 11'b0_1_0_00_00_0110,
    11'b0_1_0_00_00_0110, 11'b0_1_0_00_01_0110, 11'b0_1_0_00_00_0110,
    11'b0_1_0_11_01_0111,
    // B3ZS: legal 00V, B0V (R3), R4 adjacent, R5 0V even, R6 three zeros
    11'b1_1_1_10_10_0011, 11'b0_1_1_00_00_0011, 11'b0_1_1_00_00_0011,
    11'b0_1_1_10_00_0011, 11'b0_1_1_01_10_0011, 11'b0_1_1_10_10_0011,
    11'b0_1_1_01_00_0011, 11'b0_1_1_00_00_0011, 11'b0_1_1_01_00_0011,
    11'b0_1_1_10_10_0100, 11'b0_1_1_10_11_0100, 11'b0_1_1_01_10_0101,
    11'b0_1_1_10_10_0101, 11'b0_1_1_00_00_0101, 11'b0_1_1_10_11_0101,
    11'b0_1_1_01_10_0110, 11'b0_1_1_00_00_0110, 11'b0_1_1_00_00_0110,
    11'b0_1_1_00_01_0110,
    // dual-rail pass-through (R2)
    11'b1_0_0_10_10_0010, 11'b0_0_0_10_10_0010, 11'b0_0_0_11_11_0010,
    11'b0_0_0_00_00_0010, 11'b0_0_0_01_01_0010,
    // HDB3 first V after reset with even parity is legal (R8)
    11'b1_1_0_10_10_1000, 11'b0_1_0_01_10_1000, 11'b0_1_0_00_00_1000,
    11'b0_1_0_00_00_1000, 11'b0_1_0_00_00_1000, 11'b0_1_0_01_00_1000
  };

  logic [1:0] q_e [0:4];
  logic       q_v [0:4];
  int         q_r [0:4];

  task automatic check(input logic [1:0] act, input logic [1:0] exp, input int req);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL R%0d: outputs %b, expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input logic [1:0] sym, input logic [1:0] ex, input logic chk, input int req);
    for (int j = 4; j > 0; j--) begin
      q_e[j] = q_e[j-1]; q_v[j] = q_v[j-1]; q_r[j] = q_r[j-1];
    end
    q_e[0] = ex; q_v[0] = chk; q_r[0] = req;
    @(negedge clk);
    rx_pos = sym[1]; rx_neg = sym[0]; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0; rx_pos = 1'b0; rx_neg = 1'b0;
    if (q_v[4]) check({out_pos, out_neg}, q_e[4], q_r[4]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_en = 1'b0;
    repeat (2) @(negedge clk);
    check({out_pos, out_neg}, 2'b00, 8); // R8 reset value
    rst_n = 1'b1;
    for (int j = 0; j < 5; j++) q_v[j] = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; nrz_mode = 1'b1; b3zs_sel = 1'b0;
    rx_pos = 1'b0; rx_neg = 1'b0;
    for (int j = 0; j < 5; j++) begin q_e[j] = '0; q_v[j] = 1'b0; q_r[j] = 0; end
    do_reset();
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][10]) begin
        repeat (4) push(2'b00, 2'b00, 1'b0, 0);
        do_reset();
      end
      nrz_mode = VEC[i][9];
      b3zs_sel = VEC[i][8];
      push(VEC[i][7:6], VEC[i][5:4], 1'b1, int'(VEC[i][3:0]));
    end
    repeat (4) push(2'b00, 2'b00, 1'b0, 0);

    // R1: latency of four enables, then hold through idle cycles
    do_reset();
    nrz_mode = 1'b0;
    push(2'b10, 2'b00, 1'b0, 0);
    repeat (3) push(2'b00, 2'b00, 1'b0, 0);
    check({out_pos, out_neg}, 2'b00, 1); // R1 not yet due
    push(2'b00, 2'b00, 1'b0, 0);
    check({out_pos, out_neg}, 2'b10, 1); // R1 due now
    repeat (5) @(negedge clk);
    check({out_pos, out_neg}, 2'b10, 1); // R1 held without enable
    push(2'b00, 2'b00, 1'b0, 0);
    check({out_pos, out_neg}, 2'b00, 1); // R1 next bit

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule